// File: doc/BRIEF.md
# Prioritized IRQ/FIQ Interrupt Controller

This block collects a set of interrupt source lines into pending bits and decides which of them may interrupt a processor. Each source has a mask bit and a mode bit that steers it either to the fast interrupt request (`fiq_o`) or to the normal interrupt request (`irq_o`). A three-bit control register gates the FIQ output, the IRQ output and vectored dispatch, each on its own.

Four external lines share one source input. Their individual status is kept in a separate sub-pending register that software clears by writing ones. The shared pending bit follows the OR of those sub-pending bits.

For vectored dispatch, a two-level fixed-priority resolver picks one winner among the unmasked, pending IRQ-mode sources. The first level works inside groups of slots and the second level works across groups. The winning source number and its vector address are registered one cycle after the request shows on `irq_o`.

Top module: `intc_top`

## Requirements
- R1: After reset, all pending and sub-pending bits are 0, every source is masked, every source is in IRQ mode and all three control bits are 0, so `irq_o`, `fiq_o` and `vec_valid_o` are 0.
- R2: Source bit k (0..25, except the shared bit 21) becomes pending at the clock edge where `src_i[k]` is seen high after being low. It stays pending until a write with `wr_sel_i`=0 carries a 1 in `wr_data_i[k]`. A line that is held high does not set the bit again after it has been cleared.
- R3: If a rising edge and a clear of the same pending bit fall on the same clock edge, the bit ends up set.
- R4: A rising edge on `ext_sub_i[j]` sets sub-pending bit j. Writing with `wr_sel_i`=1 clears the sub-pending bits whose `wr_data_i[j]` is 1. Pending bit 21 equals the OR of the sub-pending bits, and a `wr_sel_i`=0 write to bit 21 has no effect on it.
- R5: A write with `wr_sel_i`=2 loads the mask register, where 1 means masked. A masked source drives neither request output nor the vector, and its pending bit is kept.
- R6: A write with `wr_sel_i`=3 loads the mode register, where 1 means FIQ. `fiq_o` is 1 when some unmasked pending source is in FIQ mode and `irq_o` is 1 when some unmasked pending source is in IRQ mode. Both follow the pending state in the cycle after the source edge.
- R7: A write with `wr_sel_i`=4 loads the control register from `wr_data_i[2:0]`: bit 0 enables FIQ, bit 1 enables IRQ and bit 2 enables vectored dispatch. Each bit gates only its own function.
- R8: Among the eligible IRQ sources, the highest bit number wins. Sources are ranked from bit 25 downward in groups of four slots: a lower slot beats a higher slot inside a group, and a lower group beats a higher group.
- R9: `vec_valid_o` is 1 one cycle after `irq_o` when control bits 1 and 2 are both set. `vec_src_o` then holds the winning bit number and `vec_addr_o` holds 0x20 + 4*(25 - bit number), which gives 0x30 for the shared bit 21. Both are 0 when `vec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 26 | Source lines; bit 21 is ignored |
| ext_sub_i | input | 4 | The four external lines sharing bit 21 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select: 0 pend clear, 1 sub clear, 2 mask, 3 mode, 4 control |
| wr_data_i | input | 26 | Write data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_valid_o | output | 1 | Vector outputs hold a winner |
| vec_src_o | output | 5 | Winning source bit number |
| vec_addr_o | output | 32 | Vector address of the winner |
| pend_o | output | 26 | Pending bits |
| sub_pend_o | output | 4 | Sub-pending bits of the shared external lines |

## Verification
The bench builds the block with its default parameters: 26 sources, four shared lines folded into bit 21, and groups of four slots. With these values bits 22 and 21 fall on either side of a group boundary, so the second-level arbitration can be tested. The fixed vector addresses 0x20 and 0x30 can also be checked directly. The table of vectors covers mask, mode and control combinations under several source patterns. Directed tests then cover edge-only capture, set beating clear, and the write-one-to-clear behaviour of the shared sub-pending bits.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_SUB  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_MODE = 3'd3,
    SEL_CTRL = 3'd4
  } intc_sel_e;

  localparam int CTL_W   = 3;
  localparam int CTL_FIQ = 0;
  localparam int CTL_IRQ = 1;
  localparam int CTL_VEC = 2;
endpackage

// File: rtl/intc_edge_pend.sv
module intc_edge_pend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] line_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = line_i & ~line_q;
    pend_d = pend_q;
    if (clr_en_i) pend_d = pend_d & ~clr_bits_i;
    pend_d = pend_d | rise;  // a new edge wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 26,
  parameter int GS = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] rank_o
);
  localparam int NG = (N + GS - 1) / GS;
  localparam int NT = NG * GS;
  localparam int SW = (GS > 1) ? $clog2(GS) : 1;

  logic [NT-1:0] ranked;
  logic [NG-1:0] g_hit;
  logic [SW-1:0] g_slot [NG];

  // rank 0 is the highest bit number
  for (genvar k = 0; k < NT; k++) begin : g_rank
    if (k < N) begin : g_real
      assign ranked[k] = req_i[N-1-k];
    end else begin : g_pad
      assign ranked[k] = 1'b0;
    end
  end

  // level one: inside each group the lowest slot wins
  for (genvar g = 0; g < NG; g++) begin : g_slave
    logic          hit_l;
    logic [SW-1:0] slot_l;
    always_comb begin
      hit_l  = 1'b0;
      slot_l = '0;
      for (int s = GS - 1; s >= 0; s--) begin
        if (ranked[g*GS+s]) begin
          hit_l  = 1'b1;
          slot_l = SW'(s);
        end
      end
    end
    assign g_hit[g]  = hit_l;
    assign g_slot[g] = slot_l;
  end

  // level two: the lowest group with a hit wins
  always_comb begin
    hit_o  = 1'b0;
    rank_o = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (g_hit[g]) begin
        hit_o  = 1'b1;
        rank_o = IW'(g * GS) + IW'(g_slot[g]);
      end
    end
    idx_o = IW'(N - 1) - rank_o;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int          NUM_SRC     = 26,
  parameter int          SUB_LINES   = 4,
  parameter int          SHARED_IDX  = 21,
  parameter int          GROUP_SLOTS = 4,
  parameter int          AW          = 32,
  parameter logic [31:0] VEC_BASE    = 32'h20,
  localparam int         IDX_W       = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [SUB_LINES-1:0] ext_sub_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [NUM_SRC-1:0]   wr_data_i,
  output logic                 irq_o,
  output logic                 fiq_o,
  output logic                 vec_valid_o,
  output logic [IDX_W-1:0]     vec_src_o,
  output logic [AW-1:0]        vec_addr_o,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic [SUB_LINES-1:0] sub_pend_o
);
  import intc_pkg::*;

  localparam logic [NUM_SRC-1:0] SHARED_BIT = NUM_SRC'(1) << SHARED_IDX;

  logic [NUM_SRC-1:0]   main_pend, active, irq_req;
  logic [NUM_SRC-1:0]   mask_q, mask_d, mode_q, mode_d;
  logic [CTL_W-1:0]     ctrl_q, ctrl_d;
  logic                 cfg_we, pend_clr, sub_clr;
  logic                 win_hit;
  logic [IDX_W-1:0]     win_idx, win_rank;
  logic                 vec_valid_d;
  logic [IDX_W-1:0]     vec_src_d;
  logic [AW-1:0]        vec_addr_d;

  assign pend_clr = wr_en_i && (intc_sel_e'(wr_sel_i) == SEL_PEND);
  assign sub_clr  = wr_en_i && (intc_sel_e'(wr_sel_i) == SEL_SUB);

  intc_edge_pend #(.W(NUM_SRC)) u_main (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (src_i & ~SHARED_BIT),
    .clr_en_i   (pend_clr),
    .clr_bits_i (wr_data_i),
    .pend_o     (main_pend)
  );

  intc_edge_pend #(.W(SUB_LINES)) u_sub (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (ext_sub_i),
    .clr_en_i   (sub_clr),
    .clr_bits_i (wr_data_i[SUB_LINES-1:0]),
    .pend_o     (sub_pend_o)
  );

  // the shared bit is a view of the sub-pending register
  assign pend_o = (main_pend & ~SHARED_BIT) | ({NUM_SRC{|sub_pend_o}} & SHARED_BIT);

  // configuration registers
  always_comb begin
    cfg_we = wr_en_i;
    mask_d = mask_q;
    mode_d = mode_q;
    ctrl_d = ctrl_q;
    case (intc_sel_e'(wr_sel_i))
      SEL_MASK: mask_d = wr_data_i;
      SEL_MODE: mode_d = wr_data_i;
      SEL_CTRL: ctrl_d = wr_data_i[CTL_W-1:0];
      default:  cfg_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
      ctrl_q <= '0;
    end else if (cfg_we) begin
      mask_q <= mask_d;
      mode_q <= mode_d;
      ctrl_q <= ctrl_d;
    end
  end

  // request outputs
  assign active  = pend_o & ~mask_q;
  assign irq_req = active & ~mode_q;
  assign irq_o   = ctrl_q[CTL_IRQ] & (|irq_req);
  assign fiq_o   = ctrl_q[CTL_FIQ] & (|(active & mode_q));

  intc_prio #(.N(NUM_SRC), .GS(GROUP_SLOTS), .IW(IDX_W)) u_prio (
    .req_i  (irq_req),
    .hit_o  (win_hit),
    .idx_o  (win_idx),
    .rank_o (win_rank)
  );

  // vector, registered one cycle behind the request
  always_comb begin
    vec_valid_d = ctrl_q[CTL_VEC] & ctrl_q[CTL_IRQ] & win_hit;
    vec_src_d   = '0;
    vec_addr_d  = '0;
    if (vec_valid_d) begin
      vec_src_d  = win_idx;
      vec_addr_d = AW'(VEC_BASE) + (AW'(win_rank) << 2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_src_o   <= '0;
      vec_addr_o  <= '0;
    end else begin
      vec_valid_o <= vec_valid_d;
      vec_src_o   <= vec_src_d;
      vec_addr_o  <= vec_addr_d;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int          NUM_SRC    = 26,
  parameter int          SHARED_IDX = 21,
  parameter int          IW         = 5,
  parameter int          AW         = 32,
  parameter logic [31:0] VEC_BASE   = 32'h20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] pend_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               vec_valid_o,
  input logic [IW-1:0]      vec_src_o,
  input logic [AW-1:0]      vec_addr_o,
  input logic [2:0]         ctrl
);
  localparam logic [NUM_SRC-1:0] OTHERS = ~(NUM_SRC'(1) << SHARED_IDX);

  AST_PEND_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(pend_o) & OTHERS & ~$past(src_i)) == '0)); // R2
  AST_FIQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ctrl[0]); // R7
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl[1]); // R7
  AST_VEC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(irq_o)); // R9
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (vec_addr_o == AW'(VEC_BASE) + AW'(4 * (NUM_SRC - 1 - int'(vec_src_o))))); // R9
  AST_VEC_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((($past(pend_o) >> vec_src_o) & NUM_SRC'(1)) != '0)); // R8
endmodule

bind intc_top intc_chk #(
  .NUM_SRC(NUM_SRC), .SHARED_IDX(SHARED_IDX), .IW(IDX_W), .AW(AW), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .pend_o(pend_o), .irq_o(irq_o),
  .fiq_o(fiq_o), .vec_valid_o(vec_valid_o), .vec_src_o(vec_src_o),
  .vec_addr_o(vec_addr_o), .ctrl(ctrl_q)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 26;
  localparam int NV = 10;

  localparam logic [NS-1:0] TV_SRC [NV] = '{
    26'h0000021, 26'h3000000, 26'h2000008, 26'h0000400, 26'h0000404,
    26'h0001000, 26'h0001000, 26'h0000080, 26'h1DFFFFF, 26'h0500000 };
  localparam logic [NS-1:0] TV_MASK [NV] = '{
    26'h0, 26'h0, 26'h2000000, 26'h0, 26'h0,
    26'h0, 26'h0, 26'h0, 26'h3FFFFFF, 26'h0 };
  localparam logic [NS-1:0] TV_MODE [NV] = '{
    26'h0, 26'h0, 26'h0, 26'h0000400, 26'h0000400,
    26'h0, 26'h0, 26'h0000080, 26'h0, 26'h0 };
  localparam logic [2:0] TV_CTL [NV] = '{
    3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
    3'b010, 3'b101, 3'b110, 3'b111, 3'b111 };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_i;
  logic [3:0]    ext_sub_i;
  logic          wr_en_i;
  logic [2:0]    wr_sel_i;
  logic [NS-1:0] wr_data_i;
  logic          irq_o, fiq_o, vec_valid_o;
  logic [4:0]    vec_src_o;
  logic [31:0]   vec_addr_o;
  logic [NS-1:0] pend_o;
  logic [3:0]    sub_pend_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ext_sub_i(ext_sub_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .irq_o(irq_o), .fiq_o(fiq_o), .vec_valid_o(vec_valid_o),
    .vec_src_o(vec_src_o), .vec_addr_o(vec_addr_o),
    .pend_o(pend_o), .sub_pend_o(sub_pend_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [NS-1:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd0, '1);
    wr(3'd1, '1);
  endtask

  function automatic int top_bit(input logic [NS-1:0] v);
    int r = -1;
    for (int i = 0; i < NS; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [NS-1:0] act, irqs;
    int w;
    logic ev;
    rst_n = 1'b0; src_i = '0; ext_sub_i = '0;
    wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state; all masked, so a pulse does not request
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 sub", 32'(sub_pend_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    chk("R1 vec", 32'(vec_valid_o), 0);
    wr(3'd4, 26'h7);
    src_i = 26'h1; @(negedge clk); src_i = '0;
    chk("R1 masked after reset", 32'(irq_o), 0);
    chk("R2 pend while masked", 32'(pend_o), 1);

    // table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      clear_all();
      wr(3'd2, TV_MASK[i]);
      wr(3'd3, TV_MODE[i]);
      wr(3'd4, NS'(TV_CTL[i]));
      src_i = TV_SRC[i];
      @(negedge clk);
      src_i = '0;
      act  = TV_SRC[i] & ~TV_MASK[i];
      irqs = act & ~TV_MODE[i];
      chk($sformatf("R6 irq v%0d", i), 32'(irq_o), 32'(TV_CTL[i][1] & (|irqs)));
      chk($sformatf("R6 fiq v%0d", i), 32'(fiq_o), 32'(TV_CTL[i][0] & (|(act & TV_MODE[i]))));
      @(negedge clk);
      w  = top_bit(irqs);
      ev = TV_CTL[i][2] & TV_CTL[i][1] & (w >= 0);
      chk($sformatf("R7 vec_valid v%0d", i), 32'(vec_valid_o), 32'(ev));
      chk($sformatf("R8 vec_src v%0d", i), 32'(vec_src_o), ev ? 32'(w) : 0);
      chk($sformatf("R9 vec_addr v%0d", i), vec_addr_o, ev ? 32'(32'h20 + 4 * (25 - w)) : 0);
    end

    clear_all();
    wr(3'd2, '0); wr(3'd3, '0); wr(3'd4, 26'h7);

    // R2: held level, write-one clear, no re-set
    src_i = 26'h200; @(negedge clk);
    chk("R2 set on edge", 32'(pend_o), 32'h200);
    wr(3'd0, 26'h200);
    chk("R2 cleared, held line no re-set", 32'(pend_o), 0);
    src_i = '0; @(negedge clk);

    // R3: edge and clear in the same cycle
    src_i = 26'h10;
    wr(3'd0, 26'h10);
    src_i = '0;
    chk("R3 set beats clear", 32'(pend_o), 32'h10);
    clear_all();

    // R4: shared external lines
    ext_sub_i = 4'b0100; @(negedge clk); ext_sub_i = '0;
    chk("R4 sub pend", 32'(sub_pend_o), 32'h4);
    chk("R4 shared bit", 32'(pend_o), 32'h200000);
    chk("R4 irq", 32'(irq_o), 1);
    @(negedge clk);
    chk("R4 vec_src", 32'(vec_src_o), 21);
    chk("R9 shared vec addr", vec_addr_o, 32'h30);
    wr(3'd0, 26'h200000);
    chk("R4 main clear ignored", 32'(pend_o), 32'h200000);
    ext_sub_i = 4'b1000; @(negedge clk); ext_sub_i = '0;
    wr(3'd1, 26'h4);
    chk("R4 partial sub clear", 32'(sub_pend_o), 32'h8);
    chk("R4 shared still set", 32'(pend_o), 32'h200000);
    wr(3'd1, 26'h8);
    chk("R4 shared cleared", 32'(pend_o), 0);
    chk("R4 irq dropped", 32'(irq_o), 0);

    // R5: masking keeps the pending bit
    src_i = 26'h8000; @(negedge clk); src_i = '0;
    chk("R5 irq before mask", 32'(irq_o), 1);
    wr(3'd2, 26'h8000);
    chk("R5 irq masked", 32'(irq_o), 0);
    chk("R5 pend kept", 32'(pend_o), 32'h8000);
    @(negedge clk);
    chk("R5 no vector", 32'(vec_valid_o), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule